// File: doc/BRIEF.md
# Three-Strobe Serial Register Master

This block lets on-chip logic read and write the 8-bit registers of an external clock/calendar device that has a single bidirectional data pin and three active-low control lines: chip select, write strobe and read strobe. Each transfer on the wire is one bit long. Chip select frames every bit, and inside that frame a write or read strobe pulse moves the bit. The width of each pulse and of the gap between bits comes from a clock-cycle count per microsecond, given as a parameter.

The user issues a transaction on a simple request port with a 4-bit register address, a write flag and write data. The master first sends the four address bits, least significant first. When the address is a register, eight data bits follow, least significant first: they are driven for a write or sampled for a read. A parameter mask marks some addresses as commands, and those send only the address. After reset the master runs eight dummy read-bit cycles so that the device returns to the start of a transaction. It holds `busy` high during that sequence and during every transaction. A one-cycle `done` pulse ends each transaction.

The data pin is split into `dio_out`, `dio_oe` and `dio_in` so the pad can sit outside the block. When nothing is happening, all strobes are high and the pin is driven high.

Top module: `ser3_master`

## Requirements
- R1: During and just after a synchronous reset, `busy`=1, `done`=0, `cs_n`=`wr_n`=`rd_n`=1, `dio_oe`=1 and `dio_out`=1.
- R2: After reset the master performs exactly 8 read-bit cycles and no write-bit cycles, and only then drops `busy`.
- R3: A request accepted while `busy`=0 (`req`=1) first sends `req_addr` as 4 write-bit cycles, bit 0 first.
- R4: With `req_write`=1 and a non-command address, 8 write-bit cycles follow the address and carry `req_wdata`, bit 0 first.
- R5: With `req_write`=0 and a non-command address, 8 read-bit cycles follow the address. The first bit sampled ends up in `rdata` bit 0 and the last in bit 7, and `rdata` is valid while `done`=1.
- R6: An address whose bit is set in `CMD_MASK` (default: addresses 14 and 15) sends only the 4 address bits, whatever the value of `req_write`.
- R7: In a write-bit cycle, `dio_out` holds the bit and `dio_oe`=1 before `cs_n` falls. They stay unchanged while `cs_n`=0. `wr_n` is low for exactly CYCLES_PER_US cycles, entirely inside the chip-select frame.
- R8: In a read-bit cycle, `dio_oe`=0 before `cs_n` falls. `rd_n` is low for exactly 2*CYCLES_PER_US cycles, and `dio_in` is sampled at the CYCLES_PER_US-th rising edge after `rd_n` falls.
- R9: Consecutive bit cycles are separated by at least CYCLES_PER_US cycles with `cs_n`=1. `wr_n` and `rd_n` are never low together, and never low while `cs_n`=1.
- R10: `busy` stays high from the accepting edge until the edge that raises `done`. `done` lasts one cycle. `req` is ignored while `busy`=1.
- R11: Write and command transactions leave `rdata` unchanged.
- R12: While idle (`busy`=0), `cs_n`=1 and the data pin is driven high (`dio_oe`=1, `dio_out`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transaction request, taken when busy is low |
| req_addr | input | ADDR_W | Register or command address |
| req_wdata | input | DATA_W | Data to write |
| req_write | input | 1 | 1 = write, 0 = read |
| busy | output | 1 | Resync sequence or transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | DATA_W | Data from the last read transaction |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| dio_out | output | 1 | Data pin output value |
| dio_oe | output | 1 | Data pin output enable |
| dio_in | input | 1 | Data pin input value |

## Verification
The bench models the device from the pins and drives the correct read bit only in the one cycle before the intended sample edge. A master that samples early or late therefore gathers inverted bits. The bench compares each captured address and write byte with the request, so a master that shifted most significant bit first would be caught even though a round trip through the model would hide it. Command addresses are issued with both values of the write flag, to expose a master that sends a data phase anyway or that disturbs `rdata`. The bench also holds a second request while the master is busy, which catches a design that starts a spurious transaction. Strobe widths and inter-bit gaps are measured for the whole run, so a counter off by one shows up as a wrong pulse width.

// File: rtl/ser3_pkg.sv
package ser3_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_CSL,
    PH_STRB,
    PH_REL,
    PH_GAP
  } phy_st_t;

  typedef enum logic [1:0] {
    SQ_RESYNC,
    SQ_IDLE,
    SQ_ADDR,
    SQ_DATA
  } seq_st_t;

endpackage

// File: rtl/ser3_bit_phy.sv
// One framed bit cycle: setup, chip select low, strobe pulse, release, gap.
module ser3_bit_phy
  import ser3_pkg::*;
#(
  parameter int US = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_read,
  input  logic wbit,
  output logic bdone,
  output logic rbit,
  output logic cs_n,
  output logic wr_n,
  output logic rd_n,
  output logic dio_out,
  output logic dio_oe,
  input  logic dio_in
);

  localparam int CW = $clog2(2 * US + 1);
  localparam logic [CW-1:0] T_LAST = CW'(US - 1);
  localparam logic [CW-1:0] R_LAST = CW'(2 * US - 1);

  phy_st_t       st;
  logic [CW-1:0] cnt;
  logic          rd_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      cnt     <= '0;
      rd_mode <= 1'b0;
      cs_n    <= 1'b1;
      wr_n    <= 1'b1;
      rd_n    <= 1'b1;
      dio_out <= 1'b1;
      dio_oe  <= 1'b1;
      bdone   <= 1'b0;
      rbit    <= 1'b0;
    end else begin
      bdone <= 1'b0;
      case (st)
        PH_IDLE: begin
          if (start) begin
            rd_mode <= is_read;
            dio_oe  <= ~is_read;
            dio_out <= is_read ? 1'b1 : wbit;
            st      <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          cs_n <= 1'b0;
          st   <= PH_CSL;
        end
        PH_CSL: begin
          if (rd_mode) rd_n <= 1'b0;
          else         wr_n <= 1'b0;
          cnt <= '0;
          st  <= PH_STRB;
        end
        PH_STRB: begin
          cnt <= cnt + 1'b1;
          if (rd_mode) begin
            if (cnt == T_LAST) rbit <= dio_in;
            if (cnt == R_LAST) begin
              rd_n <= 1'b1;
              st   <= PH_REL;
            end
          end else if (cnt == T_LAST) begin
            wr_n <= 1'b1;
            st   <= PH_REL;
          end
        end
        PH_REL: begin
          cs_n    <= 1'b1;
          dio_oe  <= 1'b1;
          dio_out <= 1'b1;
          cnt     <= '0;
          st      <= PH_GAP;
        end
        PH_GAP: begin
          cnt <= cnt + 1'b1;
          if (cnt == T_LAST) begin
            st    <= PH_IDLE;
            bdone <= 1'b1;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ser3_seq.sv
// Transaction sequencer: resync reads, address phase, optional data phase.
module ser3_seq
  import ser3_pkg::*;
#(
  parameter int                 AW       = 4,
  parameter int                 DW       = 8,
  parameter int                 RN       = 8,
  parameter logic [(1<<AW)-1:0] CMD_MASK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          bdone,
  input  logic          rbit,
  output logic          start,
  output logic          is_read,
  output logic          wbit
);

  localparam int MAXN = (RN > DW) ? ((RN > AW) ? RN : AW) : ((DW > AW) ? DW : AW);
  localparam int IW   = $clog2(MAXN + 1);

  seq_st_t       st;
  logic [IW-1:0] idx;
  logic          waiting;
  logic [AW-1:0] a_sh;
  logic [DW-1:0] w_sh;
  logic [DW-1:0] r_sh;
  logic [DW-1:0] r_nxt;
  logic          t_wr;
  logic          t_cmd;

  assign r_nxt = {rbit, r_sh[DW-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_RESYNC;
      idx     <= '0;
      waiting <= 1'b0;
      busy    <= 1'b1;
      done    <= 1'b0;
      start   <= 1'b0;
      is_read <= 1'b1;
      wbit    <= 1'b1;
      a_sh    <= '0;
      w_sh    <= '0;
      r_sh    <= '0;
      rdata   <= '0;
      t_wr    <= 1'b0;
      t_cmd   <= 1'b0;
    end else begin
      start <= 1'b0;
      done  <= 1'b0;
      case (st)
        SQ_RESYNC: begin
          if (!waiting) begin
            start   <= 1'b1;
            is_read <= 1'b1;
            waiting <= 1'b1;
          end else if (bdone) begin
            waiting <= 1'b0;
            if (idx == IW'(RN - 1)) begin
              idx  <= '0;
              busy <= 1'b0;
              st   <= SQ_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        SQ_IDLE: begin
          if (req) begin
            a_sh  <= req_addr;
            w_sh  <= req_wdata;
            t_wr  <= req_write;
            t_cmd <= CMD_MASK[req_addr];
            idx   <= '0;
            busy  <= 1'b1;
            st    <= SQ_ADDR;
          end
        end
        SQ_ADDR: begin
          if (!waiting) begin
            start   <= 1'b1;
            is_read <= 1'b0;
            wbit    <= a_sh[0];
            waiting <= 1'b1;
          end else if (bdone) begin
            waiting <= 1'b0;
            a_sh    <= a_sh >> 1;
            if (idx == IW'(AW - 1)) begin
              idx <= '0;
              if (t_cmd) begin
                busy <= 1'b0;
                done <= 1'b1;
                st   <= SQ_IDLE;
              end else begin
                st <= SQ_DATA;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        SQ_DATA: begin
          if (!waiting) begin
            start   <= 1'b1;
            is_read <= ~t_wr;
            wbit    <= w_sh[0];
            waiting <= 1'b1;
          end else if (bdone) begin
            waiting <= 1'b0;
            w_sh    <= w_sh >> 1;
            r_sh    <= r_nxt;
            if (idx == IW'(DW - 1)) begin
              idx  <= '0;
              busy <= 1'b0;
              done <= 1'b1;
              st   <= SQ_IDLE;
              if (!t_wr) rdata <= r_nxt;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ser3_master.sv
module ser3_master #(
  parameter int                     ADDR_W        = 4,
  parameter int                     DATA_W        = 8,
  parameter int                     RESYNC_N      = 8,
  parameter int                     CYCLES_PER_US = 200,
  parameter logic [(1<<ADDR_W)-1:0] CMD_MASK      = 16'hC000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs_n,
  output logic              wr_n,
  output logic              rd_n,
  output logic              dio_out,
  output logic              dio_oe,
  input  logic              dio_in
);

  logic start, is_read, wbit, bdone, rbit;

  ser3_seq #(
    .AW(ADDR_W), .DW(DATA_W), .RN(RESYNC_N), .CMD_MASK(CMD_MASK)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .busy(busy),
    .done(done), .rdata(rdata), .bdone(bdone), .rbit(rbit),
    .start(start), .is_read(is_read), .wbit(wbit)
  );

  ser3_bit_phy #(
    .US(CYCLES_PER_US)
  ) u_phy (
    .clk(clk), .rst(rst), .start(start), .is_read(is_read), .wbit(wbit),
    .bdone(bdone), .rbit(rbit), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .dio_out(dio_out), .dio_oe(dio_oe), .dio_in(dio_in)
  );

endmodule

// File: rtl/ser3_chk.sv
module ser3_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic wr_n,
  input logic rd_n,
  input logic dio_out,
  input logic dio_oe
);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!wr_n && !rd_n));

  // R9
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n || !rd_n) |-> !cs_n);

  // R7
  wr_drives_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> dio_oe);

  // R7
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && $past(!wr_n)) |-> $stable(dio_out));

  // R8
  rd_released_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !dio_oe);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && dio_oe && dio_out));

endmodule

bind ser3_master ser3_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .cs_n(cs_n),
  .wr_n(wr_n), .rd_n(rd_n), .dio_out(dio_out), .dio_oe(dio_oe)
);

// File: tb/tb_ser3_master.sv
`timescale 1ns/1ps
module tb_ser3_master;

  localparam int US = 4;
  localparam logic [15:0] MASK = 16'hC000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_write = 1'b0;
  logic       busy, done;
  logic [7:0] rdata;
  logic       cs_n, wr_n, rd_n, dio_out, dio_oe;
  logic       dio_in = 1'b0;

  always #2.5 clk = ~clk;

  ser3_master #(.CYCLES_PER_US(US), .CMD_MASK(MASK)) dut (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .busy(busy),
    .done(done), .rdata(rdata), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .dio_out(dio_out), .dio_oe(dio_oe), .dio_in(dio_in)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // device model and pin monitor
  logic [7:0] sregs [16];
  logic [7:0] emod  [16];
  bit         sl_data = 0;
  int         sl_cnt  = 0;
  logic [3:0] sl_addr = '0;
  logic [7:0] sl_byte = '0;
  int n_dummy = 0, n_wstr = 0, n_rstr = 0, n_txn = 0, n_cmd = 0;
  logic [3:0] last_addr = '0;
  logic [7:0] last_wdata = '0;
  int wr_lo = 0, rd_lo = 0, cs_hi = 0;
  int wr_min = 1000, wr_max = 0, rd_min = 1000, rd_max = 0, gap_min = 1000;
  int setup_err = 0, rel_err = 0, both_err = 0, hold_err = 0;
  bit seen_cs = 0;
  logic cs_dout = 1'b1, cs_oe = 1'b1, rd_bit = 1'b0;
  logic p_cs = 1'b1, p_wr = 1'b1, p_rd = 1'b1;

  task automatic slave_wbit(input logic b);
    n_wstr++;
    if (!sl_data) begin
      sl_addr[sl_cnt] = b;
      sl_cnt++;
      if (sl_cnt == 4) begin
        sl_cnt = 0;
        if (MASK[sl_addr]) begin
          n_cmd++; n_txn++; last_addr = sl_addr;
        end else sl_data = 1;
      end
    end else begin
      sl_byte[sl_cnt] = b;
      sl_cnt++;
      if (sl_cnt == 8) begin
        sregs[sl_addr] = sl_byte;
        last_addr = sl_addr; last_wdata = sl_byte;
        n_txn++; sl_data = 0; sl_cnt = 0;
      end
    end
  endtask

  task automatic slave_rbit(output logic b);
    n_rstr++;
    if (!sl_data) begin
      n_dummy++; sl_cnt = 0; b = 1'b1;
    end else begin
      b = sregs[sl_addr][sl_cnt];
      sl_cnt++;
      if (sl_cnt == 8) begin
        last_addr = sl_addr; n_txn++; sl_data = 0; sl_cnt = 0;
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n) cs_hi++;
      else if (p_cs) begin
        cs_dout = dio_out; cs_oe = dio_oe;
        if (seen_cs && cs_hi < gap_min) gap_min = cs_hi;
        seen_cs = 1; cs_hi = 0;
      end
      if (!cs_n && cs_oe && (dio_out != cs_dout || !dio_oe)) hold_err++;
      if (!wr_n) begin
        wr_lo++;
        if (p_wr) begin
          if (!cs_oe || !dio_oe || dio_out != cs_dout) setup_err++;
          slave_wbit(dio_out);
        end
      end else if (!p_wr) begin
        if (wr_lo < wr_min) wr_min = wr_lo;
        if (wr_lo > wr_max) wr_max = wr_lo;
        wr_lo = 0;
      end
      if (!rd_n) begin
        rd_lo++;
        if (p_rd) begin
          if (cs_oe || dio_oe) rel_err++;
          slave_rbit(rd_bit);
        end
        dio_in = (rd_lo == US) ? rd_bit : ~rd_bit;
      end else if (!p_rd) begin
        if (rd_lo < rd_min) rd_min = rd_lo;
        if (rd_lo > rd_max) rd_max = rd_lo;
        rd_lo = 0;
      end
      if ((!wr_n && !rd_n) || ((!wr_n || !rd_n) && cs_n)) both_err++;
      p_cs = cs_n; p_wr = wr_n; p_rd = rd_n;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic do_txn(input logic [3:0] a, input logic [7:0] d, input bit w);
    logic [7:0] r_before;
    int txn_before, w_before, r_before_n;
    r_before = rdata; txn_before = n_txn; w_before = n_wstr; r_before_n = n_rstr;
    @(negedge clk);
    req = 1'b1; req_addr = a; req_wdata = d; req_write = w;
    do @(negedge clk); while (!busy);
    req = 1'b0;
    do @(negedge clk); while (!done);
    chk(!busy, "R10 busy low with done", busy, 0);
    chk(n_txn == txn_before + 1, "R10 one device transaction", n_txn - txn_before, 1);
    chk(last_addr == a, "R3 address LSB first", last_addr, a);
    if (MASK[a]) begin
      chk(n_wstr - w_before == 4 && n_rstr == r_before_n, "R6 command has no data phase",
          n_wstr - w_before + n_rstr - r_before_n, 4);
      chk(rdata == r_before, "R11 rdata kept on command", rdata, r_before);
    end else if (w) begin
      emod[a] = d;
      chk(last_wdata == d, "R4 write data LSB first", last_wdata, d);
      chk(rdata == r_before, "R11 rdata kept on write", rdata, r_before);
    end else begin
      chk(n_rstr - r_before_n == 8, "R5 eight read cycles", n_rstr - r_before_n, 8);
      chk(rdata == emod[a], "R5 read data assembled", rdata, emod[a]);
    end
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
  endtask

  initial begin
    int txn0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) begin
      sregs[i] = 8'((i * 29 + 3) & 8'hFF);
      emod[i]  = sregs[i];
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(busy && !done, "R1 busy/done at reset", {busy, done}, 2);
    chk(cs_n && wr_n && rd_n, "R1 strobes high at reset", {cs_n, wr_n, rd_n}, 7);
    chk(dio_oe && dio_out, "R1 data pin driven high", {dio_oe, dio_out}, 3);
    wait_idle();
    // R2 resync
    chk(n_dummy == 8 && n_rstr == 8, "R2 eight dummy reads", n_rstr, 8);
    chk(n_wstr == 0, "R2 no writes during resync", n_wstr, 0);
    repeat (3) @(negedge clk);
    // R12 idle
    chk(cs_n && dio_oe && dio_out, "R12 idle pin state", {cs_n, dio_oe, dio_out}, 7);

    // directed cases
    do_txn(4'd1, 8'h00, 1'b0);
    do_txn(4'd3, 8'hA5, 1'b1);
    do_txn(4'd3, 8'h00, 1'b0);
    do_txn(4'd8, 8'h01, 1'b1);
    do_txn(4'd8, 8'h00, 1'b0);
    do_txn(4'd14, 8'hFF, 1'b1);
    do_txn(4'd15, 8'h00, 1'b0);
    do_txn(4'd13, 8'h80, 1'b1);
    do_txn(4'd13, 8'h00, 1'b0);

    // random mix
    for (int k = 0; k < 30; k++) begin
      do_txn(4'($urandom % 16), 8'($urandom % 256), bit'($urandom % 2));
    end

    // R10 request while busy is ignored
    txn0 = n_txn;
    @(negedge clk);
    req = 1'b1; req_addr = 4'd5; req_wdata = 8'h3C; req_write = 1'b1;
    do @(negedge clk); while (!busy);
    req = 1'b0;
    repeat (20) @(negedge clk);
    req = 1'b1; req_addr = 4'd6; req_write = 1'b0;
    repeat (30) @(negedge clk);
    req = 1'b0;
    do @(negedge clk); while (!done);
    emod[5] = 8'h3C;
    repeat (100) @(negedge clk);
    chk(n_txn == txn0 + 1, "R10 request during busy ignored", n_txn - txn0, 1);
    chk(!busy && last_addr == 4'd5, "R10 no extra transaction", last_addr, 5);

    // timing over the whole run
    chk(wr_min == US && wr_max == US, "R7 write strobe width", wr_max, US);
    chk(setup_err == 0 && hold_err == 0, "R7 data setup and hold", setup_err + hold_err, 0);
    chk(rd_min == 2 * US && rd_max == 2 * US, "R8 read strobe width", rd_max, 2 * US);
    chk(rel_err == 0, "R8 line released for reads", rel_err, 0);
    chk(gap_min >= US, "R9 gap between bits", gap_min, US);
    chk(both_err == 0, "R9 strobe framing", both_err, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule